// File: doc/BRIEF.md
# Instruction Issue Bubble Sequencer

This block sits between instruction fetch and execute in a small processor whose program words are 24 bits wide. Each fetched word arrives with a valid flag and a class hint from a small predecode lookup. The hint comes with a condition flag, which marks a true test, a taken branch or a taken skip, and a 2-bit extra-cycle field. The block turns this into an issue stream for the execute stage. It joins the two words of a double-word instruction into one 48-bit operand. It inserts all-zero NOP bubble cycles where an instruction costs more than one cycle. It squashes the instruction that a taken skip jumps over, whether that instruction is one word or two.

Both sides use valid/ready. A word is consumed when `in_valid` and `in_ready` are both high at a rising edge. An issue beat is delivered when `out_valid` and `out_ready` are both high. The fetch side must hold `in_valid` and the word steady until the word is taken. `in_ready` stays low while owed bubbles drain. When a word produces an issue beat, `in_ready` follows `out_ready`, so back-pressure from execute passes straight through to fetch. The first word of a double-word instruction is taken without producing a beat. A `flush` pulse from a taken branch throws away any partly assembled instruction, owed bubbles and pending skip. The block then starts afresh on the next valid word. Reset is synchronous and active high.

Top module: `issue_seq`

## Requirements
- R1: A word with class code 0 (plain) and a non-zero top byte issues as one beat with `out_op = {word, 24'h0}` and `out_bubble` low, and is followed by no bubble.
- R2: A word with class code 1 (pair head) is taken with `out_valid` low. The next word taken is its tail. The two issue as one beat `{head, tail}` with `out_bubble` low, followed by exactly one bubble beat.
- R3: A word with class code 3 (conditional or branch) issues and is then followed by one bubble when `in_cond` is 1, and by none when `in_cond` is 0.
- R4: A word with class code 4 (return or table access) issues and is then followed by two bubbles when `in_xtra` is 2'b10, and by one bubble for any other `in_xtra` value.
- R5: A word with class code 2 (skip) and `in_cond` at 1 issues normally. The next instruction is squashed and produces one bubble per word: one bubble for a single word, two for a pair. The squashed instruction's own class effects, including a further skip, are discarded. With `in_cond` at 0 the next instruction issues normally.
- R6: Every bubble beat has `out_bubble` high and `out_op` all zeros. While bubbles owed by an issued instruction drain, `in_ready` is low.
- R7: A word that is not the tail of a pair, has class code 0 and has a top 8 bits of zero issues as an all-zero `out_op` with `out_bubble` low, and costs one beat.
- R8: While `out_valid` is high and `out_ready` is low, the beat stays unchanged on the next cycle, and no word is taken unless it is a pair head.
- R9: In a cycle with `flush` high, `out_valid` and `in_ready` are low. A held pair head, any owed bubbles and any pending skip are discarded, so the next word is treated as a new instruction.
- R10: Reset clears any held pair head and pending skip. With `in_valid` low after reset, `out_valid` and `in_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard partial state after a taken branch |
| in_valid | input | 1 | Fetched word valid |
| in_ready | output | 1 | Fetched word accepted this cycle |
| in_word | input | 24 | Fetched program word |
| in_cls | input | 3 | Predecode class: 0 plain, 1 pair head, 2 skip, 3 conditional/branch, 4 return/table |
| in_cond | input | 1 | Test true / branch taken / skip taken |
| in_xtra | input | 2 | Extra-cycle field for class 4 |
| out_valid | output | 1 | Issue beat valid |
| out_ready | input | 1 | Execute stage accepts the beat |
| out_op | output | 48 | Issued operand; single words in the upper half |
| out_bubble | output | 1 | Beat is an inserted NOP |

## Verification
The stability property assumes that fetch keeps `in_valid`, the word and its hints unchanged from the cycle they first appear until they are taken. The bench source honours this: once it presents a word, it keeps presenting it until the handshake completes, and it only inserts idle gaps between words. The properties also assume that a tail word always follows its pair head, unless a flush or reset intervenes. They assume that a taken skip is always followed by some instruction. The generated programs end on a plain word and never split a pair.

// File: rtl/issue_pkg.sv
package issue_pkg;
  typedef enum logic [2:0] {
    CLS_ONE  = 3'd0,
    CLS_PAIR = 3'd1,
    CLS_SKIP = 3'd2,
    CLS_COND = 3'd3,
    CLS_LONG = 3'd4
  } icls_t;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_NEXT = 2'd1,
    SQ_TAIL = 2'd2
  } sq_state_t;
endpackage

// File: rtl/issue_hold.sv
module issue_hold #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              load,
  input  logic [WORD_W-1:0] d,
  output logic              vld,
  output logic [WORD_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      vld <= 1'b0;
    end else if (load) begin
      vld <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (load) q <= d;
  end
endmodule

// File: rtl/issue_bubble.sv
module issue_bubble #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             busy
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (dec && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/issue_squash.sv
module issue_squash
  import issue_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic arm,
  input  logic eat,
  input  logic eat_pair,
  output logic active
);
  sq_state_t st;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      st <= SQ_IDLE;
    end else begin
      unique case (st)
        SQ_IDLE: if (arm) st <= SQ_NEXT;
        SQ_NEXT: if (eat) st <= eat_pair ? SQ_TAIL : SQ_IDLE;
        SQ_TAIL: if (eat) st <= SQ_IDLE;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign active = (st != SQ_IDLE);
endmodule

// File: rtl/issue_seq.sv
module issue_seq
  import issue_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int MARK_W = 8,
  parameter int CNT_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  flush,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [WORD_W-1:0]     in_word,
  input  logic [2:0]            in_cls,
  input  logic                  in_cond,
  input  logic [1:0]            in_xtra,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [2*WORD_W-1:0]   out_op,
  output logic                  out_bubble
);
  localparam int OP_W = 2 * WORD_W;

  icls_t             cls;
  logic              stray;
  logic              hold_vld;
  logic [WORD_W-1:0] hold_q;
  logic              hold_load, hold_done;
  logic              bub_busy, bub_load, bub_dec;
  logic [CNT_W-1:0]  bub_val;
  logic              sq_active, sq_arm, sq_eat;

  assign cls   = icls_t'(in_cls);
  assign stray = (in_word[WORD_W-1 -: MARK_W] == '0);

  issue_hold #(.WORD_W(WORD_W)) u_hold (
    .clk(clk), .rst(rst), .clr(flush || hold_done), .load(hold_load),
    .d(in_word), .vld(hold_vld), .q(hold_q)
  );

  issue_bubble #(.CNT_W(CNT_W)) u_bub (
    .clk(clk), .rst(rst), .clr(flush), .load(bub_load),
    .load_val(bub_val), .dec(bub_dec), .busy(bub_busy)
  );

  issue_squash u_sq (
    .clk(clk), .rst(rst), .clr(flush), .arm(sq_arm), .eat(sq_eat),
    .eat_pair(cls == CLS_PAIR), .active(sq_active)
  );

  always_comb begin
    out_valid  = 1'b0;
    out_op     = '0;
    out_bubble = 1'b0;
    in_ready   = 1'b0;
    hold_load  = 1'b0;
    hold_done  = 1'b0;
    bub_load   = 1'b0;
    bub_val    = '0;
    bub_dec    = 1'b0;
    sq_arm     = 1'b0;
    sq_eat     = 1'b0;
    if (flush) begin
      out_valid = 1'b0;
    end else if (bub_busy) begin
      out_valid  = 1'b1;
      out_bubble = 1'b1;
      bub_dec    = out_ready;
    end else if (in_valid) begin
      if (sq_active) begin
        out_valid  = 1'b1;
        out_bubble = 1'b1;
        in_ready   = out_ready;
        sq_eat     = out_ready;
      end else if (hold_vld) begin
        out_valid = 1'b1;
        out_op    = {hold_q, in_word};
        in_ready  = out_ready;
        if (out_ready) begin
          hold_done = 1'b1;
          bub_load  = 1'b1;
          bub_val   = CNT_W'(1);
        end
      end else if (cls == CLS_PAIR) begin
        in_ready  = 1'b1;
        hold_load = 1'b1;
      end else begin
        out_valid = 1'b1;
        out_op    = stray ? '0 : {in_word, {WORD_W{1'b0}}};
        in_ready  = out_ready;
        if (out_ready) begin
          unique case (cls)
            CLS_COND: begin
              bub_load = in_cond;
              bub_val  = CNT_W'(1);
            end
            CLS_LONG: begin
              bub_load = 1'b1;
              bub_val  = (in_xtra == 2'b10) ? CNT_W'(2) : CNT_W'(1);
            end
            CLS_SKIP: sq_arm = in_cond;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/issue_seq_chk.sv
module issue_seq_chk #(
  parameter int OP_W = 48
) (
  input logic            clk,
  input logic            rst,
  input logic            flush,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [OP_W-1:0] out_op,
  input logic            out_bubble,
  input logic            owed
);
  // R6
  bubble_zero_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_bubble |-> out_op == '0);

  // R6
  owed_stall_chk: assert property (@(posedge clk) disable iff (rst || flush)
    owed |-> out_valid && out_bubble && !in_ready);

  // R8
  beat_hold_chk: assert property (@(posedge clk) disable iff (rst || flush)
    out_valid && !out_ready |=> out_valid && $stable(out_op) && $stable(out_bubble));

  // R9
  flush_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    flush |-> !out_valid && !in_ready);

  // R10
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !owed);
endmodule

bind issue_seq issue_seq_chk #(.OP_W(2 * WORD_W)) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op),
  .out_bubble(out_bubble), .owed(bub_busy)
);

// File: tb/sim_issue_seq.sv
module sim_issue_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] C_ONE = 3'd0, C_PAIR = 3'd1, C_SKIP = 3'd2,
                         C_COND = 3'd3, C_LONG = 3'd4;

  logic clk = 1'b0, rst = 1'b1, flush = 1'b0;
  logic in_valid = 1'b0, in_ready, in_cond = 1'b0, out_valid, out_ready = 1'b0, out_bubble;
  logic [23:0] in_word = '0;
  logic [2:0]  in_cls = '0;
  logic [1:0]  in_xtra = '0;
  logic [47:0] out_op;

  always #(CLK_PERIOD / 2) clk = ~clk;

  issue_seq u0 (
    .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_cls(in_cls), .in_cond(in_cond), .in_xtra(in_xtra),
    .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op), .out_bubble(out_bubble)
  );

  typedef struct { logic [23:0] w; logic [2:0] c; bit cd; logic [1:0] xt; } src_t;
  typedef struct { logic [47:0] op; bit bub; bit owed; string tag; } exp_t;

  src_t src[$];
  exp_t exq[$];
  int total = 0, bad = 0;
  bit sq = 0, pres = 0, flush_now = 0, rst_now = 0, had_stall = 0;
  logic [47:0] st_op;
  logic st_bub;

  task automatic chk(bit ok, string tag, logic [47:0] act, logic [47:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic push_exp(logic [47:0] op, bit bub, bit owed, string tag);
    exp_t e;
    e.op = op; e.bub = bub; e.owed = owed; e.tag = tag;
    exq.push_back(e);
  endtask

  function automatic logic [23:0] rnd_word();
    logic [23:0] w = 24'($urandom);
    if (w[23:16] == 8'h0) w[23:16] = 8'hA5;
    return w;
  endfunction

  task automatic put_one(logic [23:0] w, logic [2:0] c, bit cd, logic [1:0] xt, string tg);
    src_t s;
    int nb = 0;
    s.w = w; s.c = c; s.cd = cd; s.xt = xt;
    src.push_back(s);
    if (sq) begin
      sq = 0;
      push_exp(48'h0, 1'b1, 1'b0, "R5");
    end else begin
      push_exp((w[23:16] == 8'h0) ? 48'h0 : {w, 24'h0}, 1'b0, 1'b0, tg);
      if (c == C_COND && cd) nb = 1;
      if (c == C_LONG) nb = (xt == 2'b10) ? 2 : 1;
      for (int i = 0; i < nb; i++) push_exp(48'h0, 1'b1, 1'b1, tg);
      if (c == C_SKIP && cd) sq = 1;
    end
  endtask

  task automatic put_pair(logic [23:0] w1, logic [23:0] w2);
    src_t s;
    s.w = w1; s.c = C_PAIR; s.cd = 0; s.xt = 0;
    src.push_back(s);
    s.w = w2; s.c = C_ONE;
    src.push_back(s);
    if (sq) begin
      sq = 0;
      push_exp(48'h0, 1'b1, 1'b0, "R5");
      push_exp(48'h0, 1'b1, 1'b0, "R5");
    end else begin
      push_exp({w1, w2}, 1'b0, 1'b0, "R2");
      push_exp(48'h0, 1'b1, 1'b1, "R2");
    end
  endtask

  task automatic step(bit full_ready);
    @(negedge clk);
    if (!pres && src.size() > 0 && ($urandom % 4 != 0)) pres = 1;
    in_valid  = pres;
    in_word   = pres ? src[0].w  : '0;
    in_cls    = pres ? src[0].c  : '0;
    in_cond   = pres ? src[0].cd : 1'b0;
    in_xtra   = pres ? src[0].xt : '0;
    out_ready = full_ready ? 1'b1 : ($urandom % 3 != 0);
    flush     = flush_now;
    rst       = rst_now;
    #1;
    if (had_stall && !flush && !rst)
      chk(out_valid && out_op == st_op && out_bubble == st_bub, "R8 stall", out_op, st_op);
    had_stall = out_valid && !out_ready && !flush && !rst;
    st_op = out_op;
    st_bub = out_bubble;
    if (flush)
      chk(!out_valid && !in_ready, "R9 flush quiet", {46'h0, out_valid, in_ready}, 48'h0);
    if (!rst && out_valid && out_ready) begin
      if (exq.size() == 0) begin
        chk(1'b0, "R1 unexpected beat", out_op, 48'h0);
      end else begin
        exp_t e = exq.pop_front();
        chk(out_op == e.op, e.tag, out_op, e.op);
        chk(out_bubble == e.bub, {e.tag, " bubble"}, {47'h0, out_bubble}, {47'h0, e.bub});
        if (e.owed) chk(!in_ready, "R6 owed stall", {47'h0, in_ready}, 48'h0);
      end
    end
    if (!rst && in_valid && in_ready) begin
      void'(src.pop_front());
      pres = 0;
    end
  endtask

  task automatic drain(bit full_ready);
    int guard = 0;
    while ((src.size() > 0 || exq.size() > 0) && guard < 5000) begin
      step(full_ready);
      guard++;
    end
    if (guard >= 5000) chk(1'b0, "R1 drain", 48'(exq.size()), 48'h0);
    repeat (4) step(full_ready);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_now = 1;
    repeat (3) step(1'b1);
    rst_now = 0;
    step(1'b1);
    // R10: idle after reset
    chk(!out_valid && !in_ready, "R10 reset idle", {46'h0, out_valid, in_ready}, 48'h0);

    // directed
    put_one(24'h123456, C_ONE, 0, 0, "R1");
    put_one(24'h00ABCD, C_ONE, 0, 0, "R7");
    put_one(24'h3C0001, C_COND, 1, 0, "R3");
    put_one(24'h3C0002, C_COND, 0, 0, "R3");
    put_one(24'h4A0000, C_LONG, 0, 2'b10, "R4");
    put_one(24'h4A0001, C_LONG, 0, 2'b01, "R4");
    put_one(24'h4A0002, C_LONG, 0, 2'b00, "R4");
    put_one(24'h4A0003, C_LONG, 0, 2'b11, "R4");
    put_pair(24'hC00010, 24'h00BEEF);
    put_one(24'h2F0000, C_SKIP, 1, 0, "R5");
    put_one(24'h111111, C_LONG, 0, 2'b10, "R5");
    put_one(24'h2F0001, C_SKIP, 1, 0, "R5");
    put_pair(24'hC00020, 24'h000042);
    put_one(24'h2F0002, C_SKIP, 0, 0, "R5");
    put_one(24'h222222, C_ONE, 0, 0, "R5");
    put_one(24'h2F0003, C_SKIP, 1, 0, "R5");
    put_one(24'h2F0004, C_SKIP, 1, 0, "R5");
    put_one(24'h333333, C_ONE, 0, 0, "R5");
    drain(1'b0);

    // R9: flush discards a held pair head
    begin
      src_t s;
      s.w = 24'hC00030; s.c = C_PAIR; s.cd = 0; s.xt = 0;
      src.push_back(s);
      drain(1'b1);
      put_one(24'h444444, C_ONE, 0, 0, "R9");
      flush_now = 1; step(1'b1); flush_now = 0;
      drain(1'b1);
    end

    // R9: flush cancels a pending skip
    put_one(24'h2F0005, C_SKIP, 1, 0, "R5");
    drain(1'b0);
    sq = 0;
    put_one(24'h555555, C_ONE, 0, 0, "R9");
    flush_now = 1; step(1'b1); flush_now = 0;
    drain(1'b0);

    // R10: reset drops a held pair head
    begin
      src_t s;
      s.w = 24'hC00040; s.c = C_PAIR; s.cd = 0; s.xt = 0;
      src.push_back(s);
      drain(1'b1);
      rst_now = 1; step(1'b1); rst_now = 0;
      had_stall = 0;
      put_one(24'h666666, C_ONE, 0, 0, "R10");
      drain(1'b1);
    end

    // random mix
    for (int n = 0; n < 300; n++) begin
      int k = $urandom % 6;
      case (k)
        0: put_one(rnd_word(), C_ONE, 0, 0, "R1");
        1: put_pair(rnd_word(), {8'h00, 16'($urandom)});
        2: put_one(rnd_word(), C_SKIP, 1'($urandom), 0, "R5");
        3: put_one(rnd_word(), C_COND, 1'($urandom), 0, "R3");
        4: put_one(rnd_word(), C_LONG, 0, 2'($urandom), "R4");
        default: put_one({8'h00, 16'($urandom)}, C_ONE, 0, 0, "R7");
      endcase
    end
    put_one(24'h777777, C_ONE, 0, 0, "R1");
    drain(1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule